// File: doc/BRIEF.md
# Potentiometer Wiper Register File

This block holds the register state of a digitally controlled potentiometer: an 8-bit volatile wiper register, its non-volatile initial-value shadow, fourteen non-volatile general-purpose bytes and a volatile control register. A serial front end that is not part of this block turns host frames into single register requests. Those requests enter on a valid/ready port and each one returns exactly one response. The block drives the 8-bit tap code and the open-array (shutdown) control of the analog resistor array, and the output-type select of the serial data pin.

Non-volatile cells are modelled as flops. Their contents survive loss of power-good and are cleared only by `rst_n`. A write to any non-volatile location starts a self-timed busy window of `NV_CYCLES` clocks. While that window is open, the only request the block serves is a read of the control register. Power-up is a sequence: while `pwr_good` is low the wiper is held at mid-scale, 80h. Once power-good has been high for `RECALL_CYCLES` clocks, the wiper is reloaded from the stored initial value and `recall_done` rises. No request is accepted before that point.

Request handshake: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on `rsp_valid` one cycle later and stays there, unchanged, until `rsp_ready` is high at a clock edge. `req_ready` is low while a response is waiting and not being taken, and also while `recall_done` is low. A requester must hold its request stable until it is accepted.

Top module: `potreg_top`

## Requirements
- R1: While `pwr_good` is low, and until `recall_done` rises after reset or after power returns, the wiper code is 80h and `req_ready` is low.
- R2: Once `pwr_good` has been high for `RECALL_CYCLES` clocks, the wiper register is loaded from the stored initial value and `recall_done` goes high. Losing power-good returns the control register to its defaults: mode bit 0, run bit 1, drive bit 0, which reads as 40h. Non-volatile contents are kept.
- R3: With the control register mode bit (bit 7) at 0, a write to address 00h stores the byte in the initial-value register, loads the same byte into the wiper register, and starts a busy window.
- R4: With the mode bit at 1, a write to address 00h changes only the wiper register and starts no busy window. A read of address 00h returns the wiper register. The tap code follows the register from 00h (low end) to FFh (high end).
- R5: Reading address 00h with the mode bit at 0 returns the initial-value register and leaves the wiper register unchanged, even when the two differ.
- R6: The control register is at address 10h. Bit 7 is the mode bit, bit 6 is the run bit, bit 5 is the busy flag (read-only, and any value written to it is ignored), and bit 1 selects open-drain drive for the serial data pin. All other bits read 0.
- R7: Addresses 01h to 0Eh are non-volatile bytes. Any non-volatile write holds the busy flag at 1 for `NV_CYCLES` clocks starting at the accepting edge. After that window, the written value reads back.
- R8: While the busy flag is 1, every request other than a read of address 10h completes with `rsp_err`=1 and `rsp_rdata`=00h, and changes no state.
- R9: When the run bit is 0, the tap code is 00h and `array_open` is 1, while the wiper register keeps its value. Setting the run bit back to 1 restores the tap code to the wiper register value.
- R10: Address 0Fh reads as 00h without error, and a write to it is rejected. Addresses 11h to 1Fh are rejected for both reads and writes.
- R11: A response is held stable until `rsp_ready` accepts it, and `req_ready` stays low while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; also clears the non-volatile model |
| pwr_good | input | 1 | Supply valid; low forces mid-scale and restarts recall |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed this cycle |
| rsp_rdata | output | 8 | Read data (00h for writes and rejected requests) |
| rsp_err | output | 1 | Request rejected |
| recall_done | output | 1 | Power-up recall complete |
| wiper_code | output | 8 | Tap code to the resistor array |
| array_open | output | 1 | Array ends open and wiper tied to the low end |
| sdo_open_drain | output | 1 | Serial data pin drive type select |

## Verification
The bench goes after the address-0 steering.

A design that ignores the mode bit would either leave the wiper untouched on a non-volatile write, or disturb the wiper when the shadow is read; both are caught by comparing the tap code before and after each access. The busy window is timed by polling the control register. An off-by-several counter, or a busy flag that never sets, shows up as a clear time outside one poll step of `NV_CYCLES`. The same window is used to confirm that a blocked wiper write does not slip through.

Shutdown is tested with a wiper value that is neither 00h nor 80h. A design that clears the register instead of masking the output then fails on restore. Power-good is also dropped after the wiper has been set away from the stored value: a design that skips the recall, or that forgets to reset the control register, returns the wrong wiper or reads back the wrong control value.

// File: rtl/potreg_pkg.sv
package potreg_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 5;
  localparam int NV_WORDS = 15;  // initial value + 14 general bytes

  localparam logic [ADDR_W-1:0] ADR_WIPER   = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_NV_LAST = 5'h0E;
  localparam logic [ADDR_W-1:0] ADR_RSVD    = 5'h0F;
  localparam logic [ADDR_W-1:0] ADR_CTRL    = 5'h10;

  localparam int BIT_MODE  = 7;
  localparam int BIT_RUN   = 6;
  localparam int BIT_BUSY  = 5;
  localparam int BIT_DRIVE = 1;

  localparam logic [DATA_W-1:0] MID_CODE = 8'h80;

  typedef struct packed {
    logic mode;    // 1: address 0 is the volatile wiper only
    logic run;     // 0: shutdown
    logic drive;   // 1: open-drain serial output
  } ctrl_t;

  localparam ctrl_t CTRL_DEFAULT = '{mode: 1'b0, run: 1'b1, drive: 1'b0};

  typedef enum logic [2:0] {
    K_WIPER,
    K_NV,
    K_RSVD,
    K_CTRL,
    K_BAD
  } kind_t;
endpackage

// File: rtl/potreg_nvbank.sv
module potreg_nvbank
  import potreg_pkg::*;
#(
  parameter int                NV_CYCLES = 5_000_000,
  parameter logic [DATA_W-1:0] IVR_INIT  = 8'h80,
  parameter int                WORDS     = NV_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              start,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [3:0]        rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ivr,
  output logic              busy
);
  localparam int CNT_W = $clog2(NV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(NV_CYCLES - 1);

  logic [DATA_W-1:0] cells [WORDS];
  logic [CNT_W-1:0]  cnt;

  // Cells survive power-good loss; only rst_n clears them.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++)
        cells[w] <= (w == 0) ? IVR_INIT : '0;
    end else if (start) begin
      for (int w = 0; w < WORDS; w++)
        if (wr_idx == 4'(w)) cells[w] <= wr_data;
    end
  end

  // Self-timed write window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!pwr_good) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < WORDS; w++)
      if (rd_idx == 4'(w)) rd_data = cells[w];
  end

  assign ivr = cells[0];

  a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/potreg_recall.sv
module potreg_recall #(
  parameter int RECALL_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic done,
  output logic load
);
  localparam int CW = $clog2(RECALL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RECALL_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign load = pwr_good && !done && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!pwr_good) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (load) begin
      done <= 1'b1;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r2_done_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(pwr_good));
endmodule

// File: rtl/potreg_drive.sv
module potreg_drive
  import potreg_pkg::*;
(
  input  logic [DATA_W-1:0] wiper,
  input  logic              run,
  output logic [DATA_W-1:0] code,
  output logic              open
);
  // Shutdown masks the tap code; the register itself is untouched.
  assign code = run ? wiper : '0;
  assign open = !run;
endmodule

// File: rtl/potreg_top.sv
module potreg_top
  import potreg_pkg::*;
#(
  parameter int                NV_CYCLES     = 5_000_000,
  parameter int                RECALL_CYCLES = 4,
  parameter logic [DATA_W-1:0] IVR_INIT      = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              recall_done,
  output logic [DATA_W-1:0] wiper_code,
  output logic              array_open,
  output logic              sdo_open_drain
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] wiper_q;
  logic [DATA_W-1:0] nv_rd, ivr;
  logic              busy, rc_load;
  kind_t             kind;
  logic              acc, blocked, reject;
  logic              nv_start, wiper_we, ctrl_we;
  logic [DATA_W-1:0] rd_mux, ctrl_img;

  potreg_recall #(.RECALL_CYCLES(RECALL_CYCLES)) u_recall (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .done(recall_done), .load(rc_load));

  potreg_nvbank #(.NV_CYCLES(NV_CYCLES), .IVR_INIT(IVR_INIT), .WORDS(NV_WORDS)) u_nv (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .start(nv_start), .wr_idx(req_addr[3:0]), .wr_data(req_wdata),
    .rd_idx(req_addr[3:0]), .rd_data(nv_rd), .ivr(ivr), .busy(busy));

  potreg_drive u_drive (
    .wiper(wiper_q), .run(ctrl_q.run), .code(wiper_code), .open(array_open));

  // Address decode
  always_comb begin
    if (req_addr == ADR_WIPER)        kind = K_WIPER;
    else if (req_addr <= ADR_NV_LAST) kind = K_NV;
    else if (req_addr == ADR_RSVD)    kind = K_RSVD;
    else if (req_addr == ADR_CTRL)    kind = K_CTRL;
    else                              kind = K_BAD;
  end

  assign req_ready = recall_done && (!rsp_valid || rsp_ready);
  assign acc       = req_valid && req_ready;
  assign blocked   = busy && !(!req_write && kind == K_CTRL);
  assign reject    = blocked || (kind == K_BAD) || (req_write && kind == K_RSVD);

  assign wiper_we = acc && req_write && !reject && (kind == K_WIPER);
  assign ctrl_we  = acc && req_write && !reject && (kind == K_CTRL);
  assign nv_start = acc && req_write && !reject &&
                    ((kind == K_NV) || (kind == K_WIPER && !ctrl_q.mode));

  always_comb begin
    ctrl_img            = '0;
    ctrl_img[BIT_MODE]  = ctrl_q.mode;
    ctrl_img[BIT_RUN]   = ctrl_q.run;
    ctrl_img[BIT_BUSY]  = busy;
    ctrl_img[BIT_DRIVE] = ctrl_q.drive;
  end

  always_comb begin
    case (kind)
      K_WIPER: rd_mux = ctrl_q.mode ? wiper_q : nv_rd;
      K_NV:    rd_mux = nv_rd;
      K_CTRL:  rd_mux = ctrl_img;
      default: rd_mux = '0;
    endcase
    if (req_write || reject) rd_mux = '0;
  end

  // Wiper register: mid-scale without power, recall, then host writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wiper_q <= MID_CODE;
    else if (!pwr_good) wiper_q <= MID_CODE;
    else if (rc_load)  wiper_q <= ivr;
    else if (wiper_we) wiper_q <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= CTRL_DEFAULT;
    else if (!pwr_good) ctrl_q <= CTRL_DEFAULT;
    else if (ctrl_we) begin
      ctrl_q.mode  <= req_wdata[BIT_MODE];
      ctrl_q.run   <= req_wdata[BIT_RUN];
      ctrl_q.drive <= req_wdata[BIT_DRIVE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
      rsp_err   <= reject;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign sdo_open_drain = ctrl_q.drive;

  a_r1_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !recall_done |-> !req_ready);
  a_r1_mid_without_power: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> wiper_q == MID_CODE);
  a_r2_recall_loads_ivr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recall_done) |-> wiper_q == ivr);
  a_r3_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && kind == K_WIPER && !ctrl_q.mode && !busy && pwr_good)
    |=> (!pwr_good || (wiper_q == $past(req_wdata) && ivr == $past(req_wdata))));
  a_r5_shadow_read_keeps_wiper: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && kind == K_WIPER && pwr_good)
    |=> (!pwr_good || wiper_q == $past(wiper_q)));
  a_r8_blocked_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && busy && !(!req_write && kind == K_CTRL)) |=> (rsp_valid && rsp_err));
  a_r9_shutdown_output: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.run |-> (wiper_code == '0 && array_open));
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
endmodule

// File: tb/tb_potreg_top.sv
module tb_potreg_top;
  localparam int NV  = 40;
  localparam int RC  = 6;
  localparam logic [7:0] INIT = 8'h3C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_good = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_ready = 1'b1;
  logic       req_ready, rsp_valid, rsp_err, recall_done, array_open, sdo_open_drain;
  logic [7:0] rsp_rdata, wiper_code;

  int checks = 0, failures = 0, cyc = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  potreg_top #(.NV_CYCLES(NV), .RECALL_CYCLES(RC), .IVR_INIT(INIT)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .recall_done(recall_done), .wiper_code(wiper_code),
    .array_open(array_open), .sdo_open_drain(sdo_open_drain));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit w, input logic [4:0] a, input logic [7:0] d,
                      output logic [7:0] rd, output bit e);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; e = rsp_err;
  endtask

  task automatic wait_idle();
    logic [7:0] rd; bit e;
    for (int i = 0; i < 200; i++) begin
      xfer(1'b0, 5'h10, 8'h00, rd, e);
      if (!rd[5]) break;
    end
  endtask

  task automatic wait_recall();
    for (int i = 0; i < 50 && !recall_done; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 wiper mid in reset", wiper_code, 8'h80);
    chk("R1 ready low", req_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wiper mid before recall", wiper_code, 8'h80);
    chk("R1 recall not done", recall_done, 0);
    wait_recall();
    chk("R2 recall done", recall_done, 1);
    chk("R2 wiper from init value", wiper_code, INIT);
  endtask

  task automatic t_write_through();
    logic [7:0] rd; bit e;
    xfer(1'b1, 5'h00, 8'h5A, rd, e);
    chk("R3 write ok", e, 0);
    chk("R3 wiper follows shadow write", wiper_code, 8'h5A);
    xfer(1'b0, 5'h10, 8'h00, rd, e);
    chk("R3 busy set", rd[5], 1);
    wait_idle();
    xfer(1'b0, 5'h00, 8'h00, rd, e);
    chk("R3 shadow read back", rd, 8'h5A);
  endtask

  task automatic t_volatile();
    logic [7:0] rd; bit e;
    xfer(1'b1, 5'h10, 8'hC0, rd, e);
    xfer(1'b1, 5'h00, 8'h00, rd, e);
    chk("R4 wiper code 00h", wiper_code, 8'h00);
    xfer(1'b1, 5'h00, 8'hFF, rd, e);
    chk("R4 wiper code FFh", wiper_code, 8'hFF);
    xfer(1'b1, 5'h00, 8'h22, rd, e);
    xfer(1'b0, 5'h10, 8'h00, rd, e);
    chk("R4 no busy on volatile write", rd, 8'hC0);
    xfer(1'b0, 5'h00, 8'h00, rd, e);
    chk("R4 read returns wiper", rd, 8'h22);
    xfer(1'b1, 5'h10, 8'h40, rd, e);
    xfer(1'b0, 5'h00, 8'h00, rd, e);
    chk("R5 shadow unchanged by volatile write", rd, 8'h5A);
    chk("R5 wiper kept after shadow read", wiper_code, 8'h22);
  endtask

  task automatic t_ctrl_layout();
    logic [7:0] rd; bit e;
    xfer(1'b1, 5'h10, 8'hFF, rd, e);
    xfer(1'b0, 5'h10, 8'h00, rd, e);
    chk("R6 control image", rd, 8'hC2);
    chk("R6 drive select out", sdo_open_drain, 1);
    xfer(1'b1, 5'h10, 8'h40, rd, e);
    chk("R6 drive select cleared", sdo_open_drain, 0);
  endtask

  task automatic t_busy();
    logic [7:0] rd; bit e; int t0, t1;
    xfer(1'b1, 5'h03, 8'h77, rd, e);
    t0 = cyc;
    chk("R7 gp write ok", e, 0);
    xfer(1'b0, 5'h10, 8'h00, rd, e);
    chk("R7 busy flag", rd, 8'h60);
    xfer(1'b0, 5'h03, 8'h00, rd, e);
    chk("R8 gp read rejected", e, 1);
    chk("R8 rejected data zero", rd, 0);
    xfer(1'b1, 5'h00, 8'h99, rd, e);
    chk("R8 wiper write rejected", e, 1);
    chk("R8 wiper unchanged", wiper_code, 8'h22);
    t1 = t0;
    for (int i = 0; i < 200; i++) begin
      xfer(1'b0, 5'h10, 8'h00, rd, e);
      t1 = cyc;
      if (!rd[5]) break;
    end
    checks++;
    if ((t1 - t0) < NV || (t1 - t0) > NV + 4) begin
      failures++;
      $display("FAIL R7 busy clear time actual=%0d expected=%0d..%0d", t1 - t0, NV, NV + 4);
    end
    xfer(1'b0, 5'h03, 8'h00, rd, e);
    chk("R7 gp read back", rd, 8'h77);
  endtask

  task automatic t_shutdown();
    logic [7:0] rd; bit e;
    xfer(1'b1, 5'h10, 8'hC0, rd, e);
    xfer(1'b1, 5'h00, 8'h9B, rd, e);
    xfer(1'b1, 5'h10, 8'h80, rd, e);
    chk("R9 code forced low", wiper_code, 8'h00);
    chk("R9 array open", array_open, 1);
    xfer(1'b0, 5'h00, 8'h00, rd, e);
    chk("R9 wiper held", rd, 8'h9B);
    xfer(1'b1, 5'h10, 8'hC0, rd, e);
    chk("R9 restored", wiper_code, 8'h9B);
    chk("R9 array closed", array_open, 0);
  endtask

  task automatic t_addr();
    logic [7:0] rd; bit e;
    xfer(1'b0, 5'h0F, 8'h00, rd, e);
    chk("R10 reserved read ok", e, 0);
    chk("R10 reserved data", rd, 0);
    xfer(1'b1, 5'h0F, 8'h12, rd, e);
    chk("R10 reserved write rejected", e, 1);
    xfer(1'b0, 5'h1F, 8'h00, rd, e);
    chk("R10 out of range rejected", e, 1);
  endtask

  task automatic t_backpressure();
    logic [7:0] held;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 5'h10;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 rsp valid", rsp_valid, 1);
    held = rsp_rdata;
    chk("R11 ready low while held", req_ready, 0);
    repeat (3) @(negedge clk);
    chk("R11 still valid", rsp_valid, 1);
    chk("R11 data stable", rsp_rdata, held);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 released", rsp_valid, 0);
  endtask

  task automatic t_power();
    logic [7:0] rd; bit e;
    // mode 1, wiper away from stored shadow (5Ah)
    xfer(1'b1, 5'h00, 8'h11, rd, e);
    @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R1 mid on power loss", wiper_code, 8'h80);
    chk("R1 ready low on power loss", req_ready, 0);
    repeat (2) @(negedge clk);
    pwr_good = 1'b1;
    wait_recall();
    chk("R2 recall after power return", wiper_code, 8'h5A);
    xfer(1'b0, 5'h10, 8'h00, rd, e);
    chk("R2 control defaults", rd, 8'h40);
    xfer(1'b0, 5'h03, 8'h00, rd, e);
    chk("R2 gp kept", rd, 8'h77);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write_through();
    t_volatile();
    t_ctrl_layout();
    t_busy();
    t_shutdown();
    t_addr();
    t_backpressure();
    t_power();
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule